// File: doc/BRIEF.md
# Per-Line Bank Source Selector with Edge Interrupts

This block routes sixteen interrupt lines from a set of general-purpose pin banks. Every bank presents a 16-bit pin vector, and line i can only look at pin i. A 4-bit bank number held for each line picks which bank's pin i drives that line. The selected levels appear on `line_lvl`. Each line also has an edge detector. For each line, separate enables arm the detector for rising edges and for falling edges. A detected enabled edge sets a sticky pending bit. A mask qualifies the pending bits into one combined interrupt.

Software reaches the block through a small word-addressed register window. Writes use a single-cycle strobe and carry no handshake: the block accepts a write in any cycle, so it never applies back-pressure. The read port is combinational from `reg_raddr`. The four selector registers hold four 4-bit fields each. Line 4k+j lives in register k at bits [4j+3:4j]. Further registers hold the rising enables, the falling enables, the mask and the pending bits.

When a line's source is changed, the edge history is loaded with the new source's level in the same cycle. A level difference between the old bank and the new bank is therefore never taken for an edge.

Top module: `irqsel_top`

## Requirements
- R1: After reset, every selector field is 0 (bank 0), the rising enables, falling enables, mask and pending bits are all 0, and `irq` is 0.
- R2: `line_lvl[i]` equals pin i of the bank named in line i's selector field, that is bit (bank*16 + i) of `bank_pins`. It follows a selector write from the cycle after the write.
- R3: Selector field for line 4k+j is register address k (0..3), bits [4j+3:4j]; a write to address k replaces only lines 4k..4k+3, reads return the packed fields, and all other selector fields remain unchanged.
- R4: A selector value equal to or above NBANKS forces that line's level to 0 regardless of the pins.
- R5: Address 4 holds the rising enables and address 5 the falling enables, bit i for line i. A 0-to-1 change of line i sets pending bit i only if its rising enable is set. A 1-to-0 change sets it only if its falling enable is set. The pending bit is visible the cycle after the pin change is sampled.
- R6: Address 7 reads the pending bits in [15:0]. Writing 1 to bit i clears pending bit i. Writing 0 leaves it unchanged. A pending bit otherwise stays set.
- R7: If an enabled edge and a clearing write hit the same line in the same cycle, the pending bit ends set.
- R8: Address 6 holds the mask. `irq` is 1 exactly when some line has both its pending bit and its mask bit set.
- R9: Rewriting a line's selector never sets its pending bit by itself, even when the old and new sources differ in level and both edge enables are on.
- R10: Bits [31:16] of addresses 4 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 3 | Write word address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 3 | Read word address |
| reg_rdata | output | 32 | Read data, combinational from reg_raddr |
| bank_pins | input | NBANKS*16 | Pin vectors of all banks, bank b at bits [16b+15:16b] |
| line_lvl | output | 16 | Selected level of each line |
| irq | output | 1 | Combined masked interrupt |

## Verification
Two pairs of events can land in the same cycle. In the first pair, an enabled edge on a line meets a write-one clear of that same pending bit. The bench forces this by toggling a pin in the same cycle as the clearing write, and it expects the bit to stay set. In the second pair, a selector rewrite meets a level difference between the old and new sources. The bench sets up one bank all low and another all high, with both edge enables on, and it expects no pending bit to appear. Random traffic then mixes pin toggles, selector rewrites, out-of-range bank numbers and clears against a cycle model kept in the bench.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
  localparam int NLINES   = 16;
  localparam int SELW     = 4;
  localparam int PER_REG  = 4;
  localparam int NSELREG  = NLINES / PER_REG;
  localparam int AW       = 3;
  localparam int DW       = 32;

  typedef enum logic [AW-1:0] {
    A_SEL0 = 3'd0,
    A_SEL1 = 3'd1,
    A_SEL2 = 3'd2,
    A_SEL3 = 3'd3,
    A_RISE = 3'd4,
    A_FALL = 3'd5,
    A_MASK = 3'd6,
    A_PEND = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/irqsel_route.sv
module irqsel_route
  import irqsel_pkg::*;
#(
  parameter int NBANKS = 6
) (
  input  logic [NLINES*SELW-1:0]   sel,
  input  logic [NBANKS*NLINES-1:0] pins,
  output logic [NLINES-1:0]        lvl
);
  for (genvar i = 0; i < NLINES; i++) begin : g_line
    always_comb begin
      lvl[i] = 1'b0;
      for (int b = 0; b < NBANKS; b++) begin
        if (sel[i*SELW +: SELW] == SELW'(b)) lvl[i] = pins[b*NLINES + i];
      end
    end
  end
endmodule

// File: rtl/irqsel_edge.sv
module irqsel_edge
  import irqsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] lvl_cur,
  input  logic [NLINES-1:0] lvl_nxt,
  input  logic [NLINES-1:0] rise_en,
  input  logic [NLINES-1:0] fall_en,
  input  logic [NLINES-1:0] clr,
  output logic [NLINES-1:0] pend
);
  logic [NLINES-1:0] hist_q;
  logic [NLINES-1:0] hit;

  assign hit = (lvl_cur & ~hist_q & rise_en) | (~lvl_cur & hist_q & fall_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
      pend   <= '0;
    end else begin
      hist_q <= lvl_nxt;
      pend   <= (pend & ~clr) | hit;
    end
  end
endmodule

// File: rtl/irqsel_regs.sv
module irqsel_regs
  import irqsel_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [DW-1:0]          wdata,
  input  logic [AW-1:0]          raddr,
  input  logic [NLINES-1:0]      pend,
  output logic [NLINES*SELW-1:0] sel_q,
  output logic [NLINES*SELW-1:0] sel_nxt,
  output logic [NLINES-1:0]      rise_en,
  output logic [NLINES-1:0]      fall_en,
  output logic [NLINES-1:0]      mask,
  output logic [NLINES-1:0]      pend_clr,
  output logic [DW-1:0]          rdata
);
  localparam int REGBITS = PER_REG * SELW;

  for (genvar i = 0; i < NLINES; i++) begin : g_sel
    localparam logic [AW-1:0] MYREG = AW'(i / PER_REG);
    localparam int            MYBIT = (i % PER_REG) * SELW;
    assign sel_nxt[i*SELW +: SELW] = (we && waddr == MYREG) ?
                                     wdata[MYBIT +: SELW] : sel_q[i*SELW +: SELW];
  end

  assign pend_clr = (we && waddr == A_PEND) ? wdata[NLINES-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= '0;
      rise_en <= '0;
      fall_en <= '0;
      mask    <= '0;
    end else begin
      sel_q <= sel_nxt;
      if (we && waddr == A_RISE) rise_en <= wdata[NLINES-1:0];
      if (we && waddr == A_FALL) fall_en <= wdata[NLINES-1:0];
      if (we && waddr == A_MASK) mask    <= wdata[NLINES-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (raddr)
      A_SEL0, A_SEL1, A_SEL2, A_SEL3:
        rdata[REGBITS-1:0] = sel_q[raddr[1:0]*REGBITS +: REGBITS];
      A_RISE: rdata[NLINES-1:0] = rise_en;
      A_FALL: rdata[NLINES-1:0] = fall_en;
      A_MASK: rdata[NLINES-1:0] = mask;
      default: rdata[NLINES-1:0] = pend;
    endcase
  end
endmodule

// File: rtl/irqsel_top.sv
module irqsel_top
  import irqsel_pkg::*;
#(
  parameter int NBANKS = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [2:0]               reg_addr,
  input  logic [31:0]              reg_wdata,
  input  logic [2:0]               reg_raddr,
  output logic [31:0]              reg_rdata,
  input  logic [NBANKS*16-1:0]     bank_pins,
  output logic [15:0]              line_lvl,
  output logic                     irq
);
  logic [NLINES*SELW-1:0] sel_q;
  logic [NLINES*SELW-1:0] sel_nxt;
  logic [NLINES-1:0]      rise_en;
  logic [NLINES-1:0]      fall_en;
  logic [NLINES-1:0]      mask;
  logic [NLINES-1:0]      pend;
  logic [NLINES-1:0]      pend_clr;
  logic [NLINES-1:0]      lvl_nxt;

  irqsel_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .waddr    (reg_addr),
    .wdata    (reg_wdata),
    .raddr    (reg_raddr),
    .pend     (pend),
    .sel_q    (sel_q),
    .sel_nxt  (sel_nxt),
    .rise_en  (rise_en),
    .fall_en  (fall_en),
    .mask     (mask),
    .pend_clr (pend_clr),
    .rdata    (reg_rdata)
  );

  // live routing from the committed selectors
  irqsel_route #(.NBANKS(NBANKS)) u_route_cur (
    .sel  (sel_q),
    .pins (bank_pins),
    .lvl  (line_lvl)
  );

  // routing from the selectors as they will be after this cycle's write
  irqsel_route #(.NBANKS(NBANKS)) u_route_nxt (
    .sel  (sel_nxt),
    .pins (bank_pins),
    .lvl  (lvl_nxt)
  );

  irqsel_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl_cur (line_lvl),
    .lvl_nxt (lvl_nxt),
    .rise_en (rise_en),
    .fall_en (fall_en),
    .clr     (pend_clr),
    .pend    (pend)
  );

  assign irq = |(pend & mask);
endmodule

// File: rtl/irqsel_chk.sv
module irqsel_chk #(
  parameter int NBANKS = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [63:0] sel_q,
  input logic [15:0] rise_en,
  input logic [15:0] fall_en,
  input logic [15:0] pend,
  input logic [15:0] line_lvl,
  input logic        irq
);
  for (genvar i = 0; i < 16; i++) begin : g_line
    p_range_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(sel_q[i*4 +: 4]) >= NBANKS) |-> !line_lvl[i]);

    p_pend_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[i] && !(reg_we && reg_addr == 3'd7 && reg_wdata[i])) |=> pend[i]);

    p_pend_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[i]) |-> ($past(rise_en[i]) || $past(fall_en[i])));
  end

  for (genvar k = 0; k < 4; k++) begin : g_reg
    p_sel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_addr == 3'(k)) |=> $stable(sel_q[k*16 +: 16]));
  end

  p_irq_needs_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend != 16'd0));
endmodule

bind irqsel_top irqsel_chk #(.NBANKS(NBANKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .sel_q     (sel_q),
  .rise_en   (rise_en),
  .fall_en   (fall_en),
  .pend      (pend),
  .line_lvl  (line_lvl),
  .irq       (irq)
);

// File: tb/test_irqsel_top.sv
`timescale 1ns/1ps
module test_irqsel_top;
  localparam int NB = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [2:0]    reg_raddr = '0;
  logic [31:0]   reg_rdata;
  logic [NB*16-1:0] pins = '0;
  logic [15:0]   line_lvl;
  logic          irq;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [3:0]  m_sel [16];
  logic [15:0] m_rise, m_fall, m_mask, m_pend, m_hist;

  always #5 clk = ~clk;

  irqsel_top #(.NBANKS(NB)) i_irqsel_top (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .bank_pins(pins), .line_lvl(line_lvl), .irq(irq)
  );

  function automatic logic src_lvl(input logic [3:0] s, input int i);
    if (int'(s) < NB) return pins[int'(s)*16 + i];
    return 1'b0;
  endfunction

  function automatic logic [15:0] exp_lvl();
    logic [15:0] v;
    for (int i = 0; i < 16; i++) v[i] = src_lvl(m_sel[i], i);
    return v;
  endfunction

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    logic [31:0] v;
    v = '0;
    if (a < 3'd4) begin
      for (int j = 0; j < 4; j++) v[4*j +: 4] = m_sel[int'(a)*4 + j];
    end else if (a == 3'd4) v[15:0] = m_rise;
    else if (a == 3'd5) v[15:0] = m_fall;
    else if (a == 3'd6) v[15:0] = m_mask;
    else v[15:0] = m_pend;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m_sel[i] = '0;
    m_rise = '0; m_fall = '0; m_mask = '0; m_pend = '0; m_hist = '0;
  endtask

  task automatic model_update(input logic we, input logic [2:0] wa, input logic [31:0] wd);
    logic [3:0]  nsel [16];
    logic [15:0] lvl, set, clr;
    lvl = exp_lvl();
    for (int i = 0; i < 16; i++) nsel[i] = m_sel[i];
    if (we && wa < 3'd4)
      for (int j = 0; j < 4; j++) nsel[int'(wa)*4 + j] = wd[4*j +: 4];
    set = (lvl & ~m_hist & m_rise) | (~lvl & m_hist & m_fall);
    clr = (we && wa == 3'd7) ? wd[15:0] : 16'd0;
    m_pend = (m_pend & ~clr) | set;
    for (int i = 0; i < 16; i++) m_hist[i] = src_lvl(nsel[i], i);
    if (we && wa == 3'd4) m_rise = wd[15:0];
    if (we && wa == 3'd5) m_fall = wd[15:0];
    if (we && wa == 3'd6) m_mask = wd[15:0];
    for (int i = 0; i < 16; i++) m_sel[i] = nsel[i];
  endtask

  task automatic step(input logic we, input logic [2:0] wa, input logic [31:0] wd,
                      input logic [2:0] ra);
    @(negedge clk);
    reg_we = we; reg_addr = wa; reg_wdata = wd; reg_raddr = ra;
    model_update(we, wa, wd);
    @(posedge clk);
    #1;
    chk("R2 line level", {16'd0, line_lvl}, {16'd0, exp_lvl()});
    chk("R8 irq", {31'd0, irq}, {31'd0, |(m_pend & m_mask)});
    chk((ra == 3'd7) ? "R6 pending read" : "R3 register read", reg_rdata, exp_read(ra));
  endtask

  task automatic idle(input logic [2:0] ra);
    step(1'b0, 3'd0, 32'd0, ra);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    for (int w = 0; w < NB*16; w += 32) pins[w +: 32] = $urandom;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state through the read window
    for (int a = 0; a < 8; a++) begin
      reg_raddr = 3'(a);
      #1;
      chk("R1 reset register", reg_rdata, 32'd0);
    end
    chk("R1 reset irq", {31'd0, irq}, 32'd0);
    pins = '0;
    idle(3'd7);

    // R3: field placement, neighbours untouched
    step(1'b1, 3'd2, 32'h0000_5300, 3'd2);
    chk("R3 packed fields", reg_rdata, 32'h0000_5300);
    idle(3'd0);
    chk("R3 other register untouched", reg_rdata, 32'd0);

    // R4: out-of-range bank forces 0
    pins = '1;
    step(1'b1, 3'd0, 32'h0000_000F, 3'd0);
    chk("R4 out-of-range level", {31'd0, line_lvl[0]}, 32'd0);
    chk("R2 bank0 level", {31'd0, line_lvl[1]}, 32'd1);

    // R9: source switch with level difference and all enables on
    pins = '0;
    for (int i = 0; i < 16; i++) pins[16 + i] = 1'b1;
    step(1'b1, 3'd4, 32'h0000_FFFF, 3'd4);
    step(1'b1, 3'd5, 32'h0000_FFFF, 3'd5);
    step(1'b1, 3'd7, 32'h0000_FFFF, 3'd7);
    idle(3'd7);
    chk("R9 clean before switch", reg_rdata, 32'd0);
    step(1'b1, 3'd1, 32'h0000_1111, 3'd7);
    idle(3'd7);
    chk("R9 no spurious pending", reg_rdata, 32'd0);
    chk("R2 switched levels", {28'd0, line_lvl[7:4]}, 32'hF);

    // R5: falling edge on line 5 (bank1 pin5) sets pending
    pins[16 + 5] = 1'b0;
    idle(3'd7);
    chk("R5 falling edge pending", reg_rdata, 32'h0000_0020);
    // R6: write 0 has no effect, write 1 clears
    step(1'b1, 3'd7, 32'h0000_FFDF, 3'd7);
    chk("R6 zero bit keeps pending", reg_rdata, 32'h0000_0020);
    step(1'b1, 3'd7, 32'h0000_0020, 3'd7);
    chk("R6 clear by one", reg_rdata, 32'd0);

    // R7: edge and clear in the same cycle, set wins
    pins[16 + 5] = 1'b1;
    step(1'b1, 3'd7, 32'h0000_0020, 3'd7);
    chk("R7 set over clear", reg_rdata, 32'h0000_0020);

    // R8: mask qualifies the combined output
    chk("R8 unmasked quiet", {31'd0, irq}, 32'd0);
    step(1'b1, 3'd6, 32'h0000_0020, 3'd6);
    chk("R8 masked pending raises irq", {31'd0, irq}, 32'd1);
    step(1'b1, 3'd7, 32'h0000_FFFF, 3'd7);
    chk("R8 irq drops after clear", {31'd0, irq}, 32'd0);

    // R10: upper bits of enable/mask/pending read 0
    step(1'b1, 3'd4, 32'hFFFF_FFFF, 3'd4);
    chk("R10 upper bits zero", reg_rdata, 32'h0000_FFFF);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic        we;
      logic [2:0]  wa;
      logic [31:0] wd;
      for (int w = 0; w < NB*16; w += 32)
        pins[w +: 32] = pins[w +: 32] ^ ($urandom & $urandom & $urandom);
      we = ($urandom % 10) < 3;
      wa = 3'($urandom % 8);
      wd = $urandom;
      step(we, wa, wd, 3'($urandom % 8));
    end
    finish_run();
  end
endmodule